// File: doc/BRIEF.md
# Burst Column Address Sequencer

This block produces the column addresses for one read or write burst of a double-data-rate SDRAM controller. Software-visible settings reach it only through mode-register commands. When a command addresses the regular register, the block decodes the burst length, the beat ordering and the CAS latency and keeps them. Commands that address the extended register or a reserved register leave those settings untouched.

A burst start supplies the first column. From the next cycle on, the block emits two column addresses per clock, one for the even beat and one for the odd beat of that clock. It flags the pair that completes the burst. In sequential ordering the low column bits count upward from the start. In interleaved ordering they are the start XORed with the beat number. In both orderings the sequence wraps inside the block of columns aligned to the burst length, and the bits above that block never change. A burst stop cuts the sequence short. A new start replaces any burst in flight. A start made without a usable programmed length produces an error pulse and no addresses.

Top module: `burst_col_seq`

## Requirements
- R1: After reset, beatValid, lastBeat and startErr are 0, both column outputs are 0, casLatHalf is 0, and no burst length counts as programmed.
- R2: A regular mode write (modeBank = 00) stores the length code from modeOp[2:0] (001 = 2 beats, 010 = 4, 011 = 8), the ordering from modeOp[3] and the latency code from modeOp[6:4]. A legal burst start raises beatValid in the following cycle for exactly length/2 cycles, and lastBeat is high only in the final one.
- R3: With modeOp[3] = 0 (sequential), beat n carries start + n modulo the length in the low log2(length) column bits. The higher bits equal those of the start column.
- R4: With modeOp[3] = 1 (interleaved), beat n carries start XOR n in the low log2(length) bits. The higher bits are unchanged. colEven carries beat 2k and colOdd carries beat 2k+1 in the k-th cycle.
- R5: casLatHalf gives the programmed latency in half clocks: code 010 gives 4, 110 gives 5, 011 gives 6, and every other code, or no regular write yet, gives 0.
- R6: A mode write with modeBank other than 00 changes none of length, ordering or latency.
- R7: A burst stop without a simultaneous start makes beatValid 0 from the next cycle on. A stop while idle has no visible effect.
- R8: A burst start while no regular write has occurred, or while the stored length code is not 001, 010 or 011, raises startErr for exactly the next cycle, produces no beats, and ends any burst in flight.
- R9: A legal start during a burst restarts the sequence from the new column in the next cycle. A start wins over a stop in the same cycle.
- R10: A burst keeps the length and ordering in force at its start, even if a mode write happens during it. A start in the same cycle as a mode write uses the earlier settings.
- R11: While beatValid is 0, colEven, colOdd and lastBeat are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| modeWrite | input | 1 | Mode-register command strobe |
| modeBank | input | BANK_W | Register select during the mode command (00 = regular) |
| modeOp | input | 7 | Mode operand: [2:0] length code, [3] ordering, [6:4] latency code |
| burstStart | input | 1 | Starts a burst at startCol |
| startCol | input | COL_W | First column of the burst |
| burstStop | input | 1 | Ends the current burst early |
| beatValid | output | 1 | A column pair is presented this cycle |
| colEven | output | COL_W | Column of the even beat of this cycle |
| colOdd | output | COL_W | Column of the odd beat of this cycle |
| lastBeat | output | 1 | This pair completes the burst |
| startErr | output | 1 | The previous cycle's start was refused |
| casLatHalf | output | 3 | Programmed CAS latency in half clocks, 0 if unusable |

## Verification
Directed runs cover each length in both orderings, with start columns whose low bits sit at zero, in the middle and at the top of their aligned block. These runs separate a correct wrap from a carry into the upper column bits and separate addition from XOR. Further directed runs cover stops placed mid-burst and while idle, restarts on top of a running burst, and mode writes during a burst or in the same cycle as a start. These show whether the settings are latched per burst. Every latency code and every reserved length code is applied. Constrained-random traffic then mixes starts, stops and writes to all register selects, so that orderings and lengths switch between neighbouring bursts.

// File: rtl/burst_col_seq_pkg.sv
package burst_col_seq_pkg;
  // widest burst is 8 beats: 3 wrapping address bits, 4 pairs
  localparam int MAX_BL_LOG2 = 3;
  localparam int PAIR_W      = MAX_BL_LOG2 - 1;
  localparam int OP_W        = 7;

  typedef enum logic [1:0] {
    LEN2 = 2'd0,
    LEN4 = 2'd1,
    LEN8 = 2'd2
  } lenSel_e;

  // strobes and state handed from control to datapath
  typedef struct packed {
    logic              load;
    logic              active;
    logic              interleave;
    lenSel_e           lenSel;
    logic [PAIR_W-1:0] pairIdx;
  } seqCtl_t;
endpackage

// File: rtl/burst_col_seq_ctrl.sv
module burst_col_seq_ctrl
  import burst_col_seq_pkg::*;
#(
  parameter int BANK_W = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              modeWrite,
  input  logic [BANK_W-1:0] modeBank,
  input  logic [OP_W-1:0]   modeOp,
  input  logic              burstStart,
  input  logic              burstStop,
  output seqCtl_t           ctl,
  output logic              lastBeat,
  output logic              startErr,
  output logic [2:0]        casLatHalf
);
  logic              modeProg;
  logic [2:0]        blCode;
  logic              ilvMode;
  logic [2:0]        clCode;
  logic              active;
  logic [PAIR_W-1:0] pairIdx;
  lenSel_e           curLen;
  logic              curIlv;
  logic              errQ;

  logic              blLegal;
  lenSel_e           decLen;
  logic              startOk;
  logic [PAIR_W-1:0] lastPair;
  logic              isLast;

  // R2: length code decode, reserved codes refused (R8)
  always_comb begin
    blLegal = 1'b1;
    decLen  = LEN2;
    unique case (blCode)
      3'b001:  decLen = LEN2;
      3'b010:  decLen = LEN4;
      3'b011:  decLen = LEN8;
      default: blLegal = 1'b0;
    endcase
  end

  assign startOk = burstStart && modeProg && blLegal;

  always_comb begin
    unique case (curLen)
      LEN4:    lastPair = PAIR_W'(1);
      LEN8:    lastPair = PAIR_W'(3);
      default: lastPair = PAIR_W'(0);
    endcase
  end

  assign isLast = active && (pairIdx == lastPair);

  // R5: latency in half clocks
  always_comb begin
    casLatHalf = 3'd0;
    if (modeProg) begin
      unique case (clCode)
        3'b010:  casLatHalf = 3'd4;
        3'b110:  casLatHalf = 3'd5;
        3'b011:  casLatHalf = 3'd6;
        default: casLatHalf = 3'd0;
      endcase
    end
  end

  // burst progress; start beats stop (R9), stop ends early (R7)
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      active  <= 1'b0;
      pairIdx <= '0;
      curLen  <= LEN2;
      curIlv  <= 1'b0;
      errQ    <= 1'b0;
    end else begin
      errQ <= burstStart && !startOk;
      if (burstStart) begin
        active <= startOk;
        if (startOk) begin
          pairIdx <= '0;
          curLen  <= decLen;   // R10: settings latched per burst
          curIlv  <= ilvMode;
        end
      end else if (burstStop) begin
        active <= 1'b0;
      end else if (active) begin
        if (isLast) active <= 1'b0;
        else        pairIdx <= pairIdx + 1'b1;
      end
    end
  end

  // R6: only the regular register select updates the settings
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      modeProg <= 1'b0;
      blCode   <= 3'd0;
      ilvMode  <= 1'b0;
      clCode   <= 3'd0;
    end else if (modeWrite && (modeBank == '0)) begin
      modeProg <= 1'b1;
      blCode   <= modeOp[2:0];
      ilvMode  <= modeOp[3];
      clCode   <= modeOp[6:4];
    end
  end

  assign ctl.load       = startOk;
  assign ctl.active     = active;
  assign ctl.interleave = curIlv;
  assign ctl.lenSel     = curLen;
  assign ctl.pairIdx    = pairIdx;
  assign lastBeat       = isLast;
  assign startErr       = errQ;
endmodule

// File: rtl/burst_col_seq_dp.sv
module burst_col_seq_dp
  import burst_col_seq_pkg::*;
#(
  parameter int COL_W = 10
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [COL_W-1:0] startCol,
  input  seqCtl_t          ctl,
  output logic [COL_W-1:0] colEven,
  output logic [COL_W-1:0] colOdd
);
  localparam int LANES = 2;

  logic [COL_W-1:0]       startReg;
  logic [MAX_BL_LOG2-1:0] wrapMask;
  logic [COL_W-1:0]       laneCol [LANES];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)         startReg <= '0;
    else if (ctl.load) startReg <= startCol;
  end

  always_comb begin
    unique case (ctl.lenSel)
      LEN4:    wrapMask = 3'b011;
      LEN8:    wrapMask = 3'b111;
      default: wrapMask = 3'b001;
    endcase
  end

  // one lane per beat of the clock: even and odd
  for (genvar lane = 0; lane < LANES; lane++) begin : g_lane
    logic [MAX_BL_LOG2-1:0] beatNum;
    logic [MAX_BL_LOG2-1:0] lowSeq;
    logic [MAX_BL_LOG2-1:0] lowIlv;
    logic [MAX_BL_LOG2-1:0] lowSel;

    assign beatNum = {ctl.pairIdx, 1'(lane)};
    // R3: add and wrap; R4: xor
    assign lowSeq  = (startReg[MAX_BL_LOG2-1:0] + beatNum) & wrapMask;
    assign lowIlv  = (startReg[MAX_BL_LOG2-1:0] ^ beatNum) & wrapMask;
    assign lowSel  = (startReg[MAX_BL_LOG2-1:0] & ~wrapMask)
                   | (ctl.interleave ? lowIlv : lowSeq);
    // R11: outputs held at zero while idle
    assign laneCol[lane] = ctl.active
                         ? {startReg[COL_W-1:MAX_BL_LOG2], lowSel}
                         : '0;
  end

  assign colEven = laneCol[0];
  assign colOdd  = laneCol[1];
endmodule

// File: rtl/burst_col_seq.sv
module burst_col_seq
  import burst_col_seq_pkg::*;
#(
  parameter int COL_W  = 10,
  parameter int BANK_W = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              modeWrite,
  input  logic [BANK_W-1:0] modeBank,
  input  logic [OP_W-1:0]   modeOp,
  input  logic              burstStart,
  input  logic [COL_W-1:0]  startCol,
  input  logic              burstStop,
  output logic              beatValid,
  output logic [COL_W-1:0]  colEven,
  output logic [COL_W-1:0]  colOdd,
  output logic              lastBeat,
  output logic              startErr,
  output logic [2:0]        casLatHalf
);
  seqCtl_t ctl;

  burst_col_seq_ctrl #(.BANK_W(BANK_W)) ctrl_i (
    .clk        (clk),
    .rstN       (rstN),
    .modeWrite  (modeWrite),
    .modeBank   (modeBank),
    .modeOp     (modeOp),
    .burstStart (burstStart),
    .burstStop  (burstStop),
    .ctl        (ctl),
    .lastBeat   (lastBeat),
    .startErr   (startErr),
    .casLatHalf (casLatHalf)
  );

  burst_col_seq_dp #(.COL_W(COL_W)) dp_i (
    .clk      (clk),
    .rstN     (rstN),
    .startCol (startCol),
    .ctl      (ctl),
    .colEven  (colEven),
    .colOdd   (colOdd)
  );

  assign beatValid = ctl.active;
endmodule

// File: rtl/burst_col_seq_chk.sv
module burst_col_seq_chk #(
  parameter int COL_W  = 10,
  parameter int BANK_W = 2
) (
  input logic              clk,
  input logic              rstN,
  input logic              modeWrite,
  input logic [BANK_W-1:0] modeBank,
  input logic              burstStart,
  input logic              burstStop,
  input logic              beatValid,
  input logic [COL_W-1:0]  colEven,
  input logic [COL_W-1:0]  colOdd,
  input logic              lastBeat,
  input logic              startErr,
  input logic [2:0]        casLatHalf
);
  p_continue_r2: assert property (@(posedge clk) disable iff (!rstN)
    beatValid && !lastBeat && !burstStart && !burstStop |=> beatValid);

  p_last_ends_r2: assert property (@(posedge clk) disable iff (!rstN)
    lastBeat && !burstStart |=> !beatValid);

  p_upper_same_r3: assert property (@(posedge clk) disable iff (!rstN)
    beatValid |-> colEven[COL_W-1:3] == colOdd[COL_W-1:3]);

  p_ext_keep_r6: assert property (@(posedge clk) disable iff (!rstN)
    modeWrite && (modeBank != '0) |=> $stable(casLatHalf));

  p_stop_r7: assert property (@(posedge clk) disable iff (!rstN)
    burstStop && !burstStart |=> !beatValid);

  p_err_no_beats_r8: assert property (@(posedge clk) disable iff (!rstN)
    startErr |-> !beatValid);

  p_idle_zero_r11: assert property (@(posedge clk) disable iff (!rstN)
    !beatValid |-> (colEven == '0) && (colOdd == '0) && !lastBeat);
endmodule

bind burst_col_seq burst_col_seq_chk #(.COL_W(COL_W), .BANK_W(BANK_W)) chk_i (
  .clk        (clk),
  .rstN       (rstN),
  .modeWrite  (modeWrite),
  .modeBank   (modeBank),
  .burstStart (burstStart),
  .burstStop  (burstStop),
  .beatValid  (beatValid),
  .colEven    (colEven),
  .colOdd     (colOdd),
  .lastBeat   (lastBeat),
  .startErr   (startErr),
  .casLatHalf (casLatHalf)
);

// File: tb/burst_col_seq_tb_top.sv
module burst_col_seq_tb_top;
  localparam int COL_W = 10;

  logic             clk = 1'b0;
  logic             rstN = 1'b0;
  logic             modeWrite = 1'b0;
  logic [1:0]       modeBank = '0;
  logic [6:0]       modeOp = '0;
  logic             burstStart = 1'b0;
  logic [COL_W-1:0] startCol = '0;
  logic             burstStop = 1'b0;
  logic             beatValid;
  logic [COL_W-1:0] colEven, colOdd;
  logic             lastBeat, startErr;
  logic [2:0]       casLatHalf;

  int vectors = 0;
  int fails = 0;
  bit done = 1'b0;
  string tag = "R1";

  // bench model of the requirements
  bit mProg, mIlv, mActive, mErr, mCurIlv;
  int mBl, mCl, mLen, mPair, mStart;

  always #5 clk = ~clk;

  burst_col_seq #(.COL_W(COL_W), .BANK_W(2)) dut_i (
    .clk(clk), .rstN(rstN), .modeWrite(modeWrite), .modeBank(modeBank),
    .modeOp(modeOp), .burstStart(burstStart), .startCol(startCol),
    .burstStop(burstStop), .beatValid(beatValid), .colEven(colEven),
    .colOdd(colOdd), .lastBeat(lastBeat), .startErr(startErr),
    .casLatHalf(casLatHalf)
  );

  function automatic logic [6:0] mkOp(int bl, int ilv, int cl);
    return {cl[2:0], ilv[0], bl[2:0]};
  endfunction

  function automatic int lenOf(int code);
    return (code == 1) ? 2 : (code == 2) ? 4 : (code == 3) ? 8 : 0;
  endfunction

  function automatic int expCas();
    if (!mProg) return 0;
    return (mCl == 2) ? 4 : (mCl == 6) ? 5 : (mCl == 3) ? 6 : 0;
  endfunction

  function automatic int expCol(int n);
    int off, low;
    if (!mActive) return 0;
    off = mStart % mLen;
    low = mCurIlv ? (off ^ n) : ((off + n) % mLen);
    return mStart - off + low;
  endfunction

  task automatic cmp(string field, int act, int exp);
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual=%0d expected=%0d at %0t", tag, field, act, exp, $time);
    end
  endtask

  task automatic checkNow();
    bit expLast;
    vectors++;
    expLast = mActive && (mPair == mLen / 2 - 1);
    cmp("beatValid", int'(beatValid), int'(mActive));
    cmp("lastBeat", int'(lastBeat), int'(expLast));
    cmp("colEven", int'(colEven), expCol(2 * mPair));
    cmp("colOdd", int'(colOdd), expCol(2 * mPair + 1));
    cmp("startErr", int'(startErr), int'(mErr));
    cmp("casLatHalf", int'(casLatHalf), expCas());
  endtask

  // one clock: check what the last edge produced, then drive and predict
  task automatic step(bit mw, int bank, logic [6:0] op, bit bs, int col, bit stop);
    bit legal;
    @(negedge clk);
    checkNow();
    modeWrite = mw; modeBank = bank[1:0]; modeOp = op;
    burstStart = bs; startCol = col[COL_W-1:0]; burstStop = stop;
    legal = mProg && (lenOf(mBl) != 0);
    mErr = bs && !legal;
    if (bs) begin
      mActive = legal;
      if (legal) begin
        mPair = 0; mStart = col % (1 << COL_W);
        mLen = lenOf(mBl); mCurIlv = mIlv;
      end
    end else if (stop) mActive = 0;
    else if (mActive) begin
      if (mPair == mLen / 2 - 1) mActive = 0;
      else mPair++;
    end
    if (mw && bank == 0) begin
      mProg = 1; mBl = int'(op[2:0]); mIlv = op[3]; mCl = int'(op[6:4]);
    end
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) step(0, 0, '0, 0, 0, 0);
  endtask

  task automatic prog(int bank, int bl, int ilv, int cl);
    step(1, bank, mkOp(bl, ilv, cl), 0, 0, 0);
  endtask

  task automatic burst(int col);
    step(0, 0, '0, 1, col, 0);
    idle(5);
  endtask

  initial begin
    #(10 * 200000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog R1: actual=timeout expected=finish");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2024));
    mProg = 0; mIlv = 0; mActive = 0; mErr = 0; mCurIlv = 0;
    mBl = 0; mCl = 0; mLen = 2; mPair = 0; mStart = 0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R1: reset state
    tag = "R1"; idle(2);
    // R8: start with no programmed mode
    tag = "R8"; burst(37);
    // R5: every latency code
    tag = "R5";
    for (int c = 0; c < 8; c++) begin prog(0, 2, 0, c); idle(1); end
    // R2 R3: each length, sequential, low/mid/top of aligned block
    tag = "R2 R3";
    for (int b = 1; b <= 3; b++) begin
      prog(0, b, 0, 2);
      burst(10'h3F8); burst(10'h2AE); burst(10'h3FF); burst(10'h005);
    end
    // R4: interleaved, all lengths
    tag = "R4";
    for (int b = 1; b <= 3; b++) begin
      prog(0, b, 1, 3);
      burst(10'h105); burst(10'h0FF); burst(10'h3FA);
    end
    // R6: extended and reserved selects do not disturb settings
    tag = "R6";
    prog(0, 3, 0, 6);
    prog(1, 1, 1, 2); prog(2, 2, 1, 3); prog(3, 0, 1, 0);
    burst(10'h1C3);
    // R7: stop mid-burst and stop while idle
    tag = "R7";
    step(0, 0, '0, 1, 10'h2D, 0); idle(1); step(0, 0, '0, 0, 0, 1); idle(3);
    step(0, 0, '0, 0, 0, 1); idle(2);
    // R9: restart, and start beating a stop
    tag = "R9";
    step(0, 0, '0, 1, 10'h011, 0); idle(1);
    step(0, 0, '0, 1, 10'h236, 0); idle(1);
    step(0, 0, '0, 1, 10'h0E4, 1); idle(5);
    // R10: mode write inside a burst and with a start
    tag = "R10";
    step(0, 0, '0, 1, 10'h0C6, 0);
    prog(0, 1, 1, 2); idle(4);
    prog(0, 3, 0, 2);
    step(1, 0, mkOp(1, 1, 2), 1, 10'h35B, 0); idle(6);
    // R8: reserved length codes, and abort of a running burst
    tag = "R8";
    for (int b = 0; b < 8; b++) begin
      if (lenOf(b) == 0) begin prog(0, b, 0, 2); burst(10'h077); end
    end
    prog(0, 3, 1, 2);
    step(0, 0, '0, 1, 10'h0A0, 0); idle(1);
    prog(0, 5, 0, 2); step(0, 0, '0, 1, 10'h0A8, 0); idle(3);
    // random mix: R2 R3 R4 R6 R7 R9 R10 R11
    tag = "R2 R3 R4 R9 R11";
    for (int i = 0; i < 3000; i++) begin
      int r, bk, bl;
      bit mw, bs, st;
      r  = $urandom % 100;
      mw = (r < 10);
      bk = (($urandom % 4) == 0) ? ($urandom % 4) : 0;
      bl = (($urandom % 8) == 0) ? ($urandom % 8) : 1 + ($urandom % 3);
      bs = (($urandom % 100) < 15);
      st = (($urandom % 100) < 5);
      step(mw, bk, mkOp(bl, $urandom % 2, $urandom % 8), bs, $urandom % 1024, st);
    end
    idle(2);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule